// File: doc/BRIEF.md
# DRAM CAS-before-RAS Refresh Scheduler

This block keeps a fast-page-mode DRAM refreshed. A free-running clock divider marks one refresh slot every `CLK_KHZ * WINDOW_MS / REFRESH_ROWS` clocks. That is the even spacing needed for every row to be refreshed once per retention window (4,096 rows in 64 ms, about 15.6 us apart). Each slot adds one to a count of owed refreshes. While anything is owed, the block asks the memory access controller for the bus.

When the controller grants, the block takes over the strobes. It lowers both byte CAS strobes first. After a setup time it lowers RAS and holds RAS low for its minimum width. It then returns both strobes high, keeps the bus through a RAS precharge time, and releases it with a one-cycle completion pulse. WE stays high for the whole cycle. The DRAM's internal row counter picks the row, so no address is produced.

The controller may withhold the grant while it finishes a page burst. The owed count then grows, and the refreshes are later issued back to back. If the count reaches its limit, a sticky flag reports that the retention guarantee may have been broken.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `ras_n`, `cas_lo_n`, `cas_hi_n` and `we_n` are 1, and `req`, `own`, `done` and `overdue` are 0.
- R2: A refresh slot occurs every INTERVAL = CLK_KHZ*WINDOW_MS/REFRESH_ROWS clocks. The first slot after reset makes `req` rise exactly INTERVAL+1 clocks after the last reset edge.
- R3: `req` is 1 exactly when the owed count is non-zero. Each slot adds one to the count unless the count is at DEBT_MAX.
- R4: A grant is acted on only in a cycle where `req` is 1 and no sequence is running. A grant at any other time has no effect.
- R5: In the cycle after an accepted grant, `own` is 1 and both CAS strobes are 0. RAS stays 1 for CSR_CYC cycles with CAS low, and RAS is never 0 while CAS is 1.
- R6: RAS is 0 for exactly RAS_CYC cycles with both CAS strobes 0. RAS and both CAS strobes then return to 1 in the same cycle.
- R7: After that, `own` stays 1 with all strobes high for PRE_CYC cycles. In the next cycle `done` is 1 for one cycle and `own` is 0.
- R8: `we_n` is 1 in every cycle.
- R9: Each completed refresh lowers the owed count by one in the cycle `done` is 1. With the grant held, owed refreshes run back to back, and a new sequence may start from the `done` cycle.
- R10: The owed count never exceeds DEBT_MAX. `overdue` becomes 1 when the count reaches DEBT_MAX and stays 1 until reset.
- R11: If a slot and a completion fall in the same cycle, the owed count is unchanged. At DEBT_MAX, the completion still lowers the count and the slot is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gnt | input | 1 | Bus grant from the access controller |
| req | output | 1 | Refresh wanted (owed count non-zero) |
| own | output | 1 | Scheduler drives the strobes this cycle |
| ras_n | output | 1 | Row strobe override, active low |
| cas_lo_n | output | 1 | Low byte column strobe override, active low |
| cas_hi_n | output | 1 | High byte column strobe override, active low |
| we_n | output | 1 | Write enable override, held high |
| done | output | 1 | One-cycle pulse when a refresh cycle has ended |
| overdue | output | 1 | Sticky flag: owed count reached DEBT_MAX |

## Verification
The hardest cases to reach are the two count corners: saturation at the owed limit, and a slot landing in the same cycle as a completion. Both need the grant withheld across many intervals and then released at a chosen phase. The stimulus withholds the grant for a counted number of intervals and then drains the debt with a steady grant. It also runs long random grant patterns so that completions hit slot cycles many times. A cycle-level reference model in the bench follows the owed count through every one of those collisions.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CAS  = 2'd1,
    SEQ_RAS  = 2'd2,
    SEQ_PRE  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int INTERVAL = 1562
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end

  assert_tick_single_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/rfsh_debt_counter.sv
module rfsh_debt_counter #(
  parameter int DEBT_MAX = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic fin,
  output logic pending,
  output logic overdue
);
  localparam int DW = $clog2(DEBT_MAX + 1);
  localparam logic [DW-1:0] CAP = DW'(DEBT_MAX);

  logic [DW-1:0] debt_q, debt_d;
  logic          inc, dec;

  assign inc = tick && (debt_q != CAP);
  assign dec = fin && (debt_q != '0);

  always_comb begin
    debt_d = debt_q;
    if (inc && !dec) debt_d = debt_q + 1'b1;
    else if (dec && !inc) debt_d = debt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      debt_q  <= '0;
      pending <= 1'b0;
      overdue <= 1'b0;
    end else begin
      debt_q  <= debt_d;
      pending <= (debt_d != '0);
      overdue <= overdue | (debt_d == CAP);
    end
  end

  assert_debt_bound_R10: assert property (@(posedge clk) disable iff (rst)
    debt_q <= CAP);
  assert_overdue_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    overdue |=> overdue);
  assert_fin_owed_R9: assert property (@(posedge clk) disable iff (rst)
    fin |-> pending);
endmodule

// File: rtl/rfsh_cbr_sequencer.sv
module rfsh_cbr_sequencer
  import cbr_refresh_pkg::*;
#(
  parameter int CSR_CYC = 2,
  parameter int RAS_CYC = 4,
  parameter int PRE_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pending,
  input  logic gnt,
  output logic fin,
  output logic own,
  output logic ras_n,
  output logic cas_n,
  output logic done
);
  localparam int M1 = (CSR_CYC > RAS_CYC) ? CSR_CYC : RAS_CYC;
  localparam int MX = (M1 > PRE_CYC) ? M1 : PRE_CYC;
  localparam int CW = (MX > 1) ? $clog2(MX) : 1;

  seq_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    fin     = 1'b0;
    unique case (state_q)
      SEQ_IDLE: if (pending && gnt) begin
        state_d = SEQ_CAS;
        cnt_d   = CW'(CSR_CYC - 1);
      end
      SEQ_CAS: if (cnt_q == '0) begin
        state_d = SEQ_RAS;
        cnt_d   = CW'(RAS_CYC - 1);
      end else cnt_d = cnt_q - 1'b1;
      SEQ_RAS: if (cnt_q == '0) begin
        state_d = SEQ_PRE;
        cnt_d   = CW'(PRE_CYC - 1);
      end else cnt_d = cnt_q - 1'b1;
      SEQ_PRE: if (cnt_q == '0) begin
        state_d = SEQ_IDLE;
        fin     = 1'b1;
      end else cnt_d = cnt_q - 1'b1;
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      own     <= 1'b0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      own     <= (state_d != SEQ_IDLE);
      ras_n   <= (state_d != SEQ_RAS);
      cas_n   <= !((state_d == SEQ_CAS) || (state_d == SEQ_RAS));
      done    <= fin;
    end
  end

  assert_cas_leads_R5: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> !cas_n);
  assert_cas_before_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> $past(!cas_n));
  assert_joint_release_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> $rose(cas_n));
  assert_done_releases_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !own);
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched #(
  parameter int CLK_KHZ      = 100000,
  parameter int WINDOW_MS    = 64,
  parameter int REFRESH_ROWS = 4096,
  parameter int CSR_CYC      = 2,
  parameter int RAS_CYC      = 4,
  parameter int PRE_CYC      = 3,
  parameter int DEBT_MAX     = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic gnt,
  output logic req,
  output logic own,
  output logic ras_n,
  output logic cas_lo_n,
  output logic cas_hi_n,
  output logic we_n,
  output logic done,
  output logic overdue
);
  localparam int INTERVAL = (CLK_KHZ * WINDOW_MS) / REFRESH_ROWS;

  logic tick, fin, cas_n;

  rfsh_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst(rst), .tick(tick)
  );

  rfsh_debt_counter #(.DEBT_MAX(DEBT_MAX)) u_debt (
    .clk(clk), .rst(rst), .tick(tick), .fin(fin),
    .pending(req), .overdue(overdue)
  );

  rfsh_cbr_sequencer #(
    .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .pending(req), .gnt(gnt), .fin(fin),
    .own(own), .ras_n(ras_n), .cas_n(cas_n), .done(done)
  );

  assign cas_lo_n = cas_n;
  assign cas_hi_n = cas_n;
  assign we_n     = 1'b1;

  assert_grant_gated_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(own) |-> $past(req && gnt));
  assert_req_drop_on_done_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(req) |-> done);
endmodule

// File: tb/cbr_refresh_sched_bench.sv
module cbr_refresh_sched_bench;
  localparam int CLK_P = 10;
  localparam int KHZ   = 6400;
  localparam int INTV  = KHZ * 64 / 4096;
  localparam int CSR   = 2;
  localparam int RASC  = 4;
  localparam int PRE   = 3;
  localparam int DMAX  = 8;

  logic clk = 0, rst = 1, gnt = 0;
  logic req, own, ras_n, cas_lo_n, cas_hi_n, we_n, done, overdue;

  always #(CLK_P / 2) clk = ~clk;

  cbr_refresh_sched #(
    .CLK_KHZ(KHZ), .WINDOW_MS(64), .REFRESH_ROWS(4096),
    .CSR_CYC(CSR), .RAS_CYC(RASC), .PRE_CYC(PRE), .DEBT_MAX(DMAX)
  ) u_cbr_refresh_sched (
    .clk(clk), .rst(rst), .gnt(gnt), .req(req), .own(own), .ras_n(ras_n),
    .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n), .we_n(we_n), .done(done),
    .overdue(overdue)
  );

  int nchk = 0, nfail = 0;
  bit armed = 0, finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  int m_tcnt, m_debt, m_ph, m_pc, m_nd;
  bit m_tick, m_req, m_ovf, m_done, m_tk, m_fin;

  always @(posedge clk) begin
    if (rst) begin
      m_tcnt <= 0; m_tick <= 0; m_debt <= 0; m_req <= 0; m_ovf <= 0;
      m_ph <= 0; m_pc <= 0; m_done <= 0;
    end else begin
      m_tk  = (m_tcnt == INTV - 1);
      m_fin = (m_ph == 3) && (m_pc == PRE - 1);
      m_tcnt <= m_tk ? 0 : m_tcnt + 1;
      m_tick <= m_tk;
      m_done <= m_fin;
      case (m_ph)
        0: if (m_debt != 0 && gnt) begin m_ph <= 1; m_pc <= 0; end
        1: if (m_pc == CSR - 1) begin m_ph <= 2; m_pc <= 0; end else m_pc <= m_pc + 1;
        2: if (m_pc == RASC - 1) begin m_ph <= 3; m_pc <= 0; end else m_pc <= m_pc + 1;
        default: if (m_fin) begin m_ph <= 0; m_pc <= 0; end else m_pc <= m_pc + 1;
      endcase
      // R11: slot and completion in one cycle cancel; slot dropped at cap
      m_nd = m_debt + ((m_tick && m_debt < DMAX) ? 1 : 0) - (m_fin ? 1 : 0);
      m_debt <= m_nd;
      m_req  <= (m_nd != 0);
      m_ovf  <= m_ovf || (m_nd == DMAX);
    end
  end

  always @(negedge clk) begin
    if (armed && !rst && !finished) begin
      chk("R6 ras_n", ras_n, (m_ph != 2));
      chk("R5 cas_lo_n", cas_lo_n, (m_ph == 0 || m_ph == 3));
      chk("R5 cas_hi_n", cas_hi_n, (m_ph == 0 || m_ph == 3));
      chk("R4/R7 own", own, (m_ph != 0));
      chk("R7 done", done, m_done);
      chk("R3/R9/R11 req", req, m_req);
      chk("R10 overdue", overdue, m_ovf);
      chk("R8 we_n", we_n, 1);
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    nfail++;
    $display("FAIL watchdog expired act=1 exp=0");
    finish_run();
  end

  initial begin
    int cyc;
    int ndone;
    void'($urandom(32'h5EED1234));
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 ras_n", ras_n, 1); chk("R1 cas_lo_n", cas_lo_n, 1);
    chk("R1 cas_hi_n", cas_hi_n, 1); chk("R1 we_n", we_n, 1);
    chk("R1 req", req, 0); chk("R1 own", own, 0);
    chk("R1 done", done, 0); chk("R1 overdue", overdue, 0);
    rst = 0;
    armed = 1;
    // R2: first request timing
    cyc = 0;
    while (cyc < 4 * INTV) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (req) break;
    end
    chk("R2 first req cycle", cyc, INTV + 1);
    // R9: postpone three more slots, then burst
    repeat (3 * INTV) @(negedge clk);
    gnt = 1;
    ndone = 0;
    for (int i = 0; i < 20 * INTV; i++) begin
      @(negedge clk);
      if (done) ndone++;
      if (!req) break;
    end
    chk("R9 burst completions", ndone, 4);
    gnt = 0;
    // random grants
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      gnt = (($urandom % 100) < 40);
    end
    // R10: starve until saturation
    gnt = 0;
    repeat (10 * INTV) @(negedge clk);
    chk("R10 overdue after starvation", overdue, 1);
    chk("R3 req while owed", req, 1);
    gnt = 1;
    repeat (400) @(negedge clk);
    chk("R10 overdue sticky", overdue, 1);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      gnt = (($urandom % 100) < 25);
    end
    @(negedge clk);
    finish_run();
  end
endmodule